// File: doc/BRIEF.md
# Tagged-Register Element Issue Sequencer

This block sits in the pipeline between instruction decode and the execution units. Every decoded scalar instruction is checked against a table that holds one tag bit per architectural register. The check covers the destination and both sources, and each operand carries its own enable. If no enabled operand is tagged, the instruction goes out unchanged, once. The program counter then moves on as usual.

If any enabled operand is tagged, the instruction becomes a loop. It is re-issued once per element, and the element count comes from a length register. On each issue the tagged register numbers are raised by the element index, while untagged operands keep their numbers. Decode is held off for the whole loop. The PC-advance strobe fires only when the last element is handed over.

A register number may be about to pass the top of the register file. In that case issue stops and a range exception is raised; the number does not wrap. A build-time option gives a minimal version. In that version a tagged instruction raises an exception at once, so that software can run the loop, and untagged instructions still pass through.

Top module: `elem_issue_seq`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and after it is released, in_ready is 1, out_valid is 0 and exc_valid is 0. After reset all register tags are clear and the length value is 1.
- R2: An instruction with no tagged enabled operand is issued exactly once. Its op, register numbers and enables are unchanged, out_elem is 0, and pc_advance is 1 in the cycle of its output handshake.
- R3: An instruction with a tagged enabled operand, accepted while the length value is L, is issued max(L,1) times. in_ready stays 0 from the accept until the loop ends. pc_advance is 1 only in the cycle of the final element's handshake.
- R4: For element e, each tagged enabled operand comes out as its register number plus e. Every other operand comes out with its original number.
- R5: The element index advances only in a cycle where out_valid and out_ready are both 1. While out_ready is 0, every output field holds its value.
- R6: A length value of 0 or 1 issues a tagged instruction once, with element index 0 and no offset, and then asserts pc_advance.
- R7: An element whose tagged operand would exceed register 31 is not issued. In the next cycle exc_valid is 1 for one cycle with exc_code 2 (range), pc_advance is not asserted, and the block returns to idle.
- R8: Length and tag writes made while an instruction is being sequenced are ignored. Writes made while idle take effect for instructions accepted in later cycles.
- R9: With TRAP_ON_TAG set, an instruction with a tagged enabled operand is not issued. In the cycle after its accept, exc_valid is 1 with exc_code 1 (tagged), and pc_advance stays 0. Untagged instructions behave as in R2.
- R10: An operand whose enable input is 0 is neither looked up for a tag nor offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_len_we | input | 1 | Length register write strobe |
| csr_len_wdata | input | LEN_W | Length write value |
| csr_tag_we | input | 1 | Tag table write strobe |
| csr_tag_idx | input | RW | Register whose tag is written |
| csr_tag_val | input | 1 | Tag value to write |
| in_valid | input | 1 | Decoded instruction valid |
| in_ready | output | 1 | Sequencer can accept an instruction |
| in_op | input | OP_W | Opaque operation payload |
| in_rd | input | RW | Destination register number |
| in_rs1 | input | RW | First source register number |
| in_rs2 | input | RW | Second source register number |
| in_rd_en | input | 1 | Destination is used |
| in_rs1_en | input | 1 | First source is used |
| in_rs2_en | input | 1 | Second source is used |
| out_valid | output | 1 | Element issue valid |
| out_ready | input | 1 | Execution side accepts the element |
| out_op | output | OP_W | Operation payload |
| out_rd | output | RW | Destination register for this element |
| out_rs1 | output | RW | First source for this element |
| out_rs2 | output | RW | Second source for this element |
| out_rd_en | output | 1 | Destination used |
| out_rs1_en | output | 1 | First source used |
| out_rs2_en | output | 1 | Second source used |
| out_elem | output | LEN_W | Element index of this issue |
| pc_advance | output | 1 | PC may move to the next instruction |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_code | output | 2 | 0 none, 1 tagged trap, 2 register range |

## Verification
A wrong element counter or loop count shows up at once as an out_elem value or register number that does not match, and at the end of the loop as pc_advance on the wrong handshake or an extra or missing issue. A corrupted tag table or length register shows on the next instruction after the bad write, as an issue count or offset pattern that is wrong. The bench writes the configuration in the middle of a loop, so a write that slips past the lock surfaces as exactly that mismatch. A wrong range check shows in the cycle the bad element is due: an issue appears where a silent cycle followed by a code-2 exception was expected.

// File: rtl/seq_pkg.sv
`timescale 1ns/1ps
package seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FAULT = 2'd2
  } seq_state_e;

  localparam logic [1:0] EXC_NONE   = 2'd0;
  localparam logic [1:0] EXC_TAGGED = 2'd1;
  localparam logic [1:0] EXC_RANGE  = 2'd2;

  // operand slots: 0 = destination, 1 = source 1, 2 = source 2
  localparam int NOPND = 3;
endpackage

// File: rtl/seq_tag_table.sv
`timescale 1ns/1ps
module seq_tag_table #(
  parameter int NREG = 32,
  parameter int NRD  = 3,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lock,
  input  logic                    we,
  input  logic [RW-1:0]           widx,
  input  logic                    wval,
  input  logic [NRD-1:0][RW-1:0]  ridx,
  output logic [NRD-1:0]          rtag
);
  logic [NREG-1:0] tag_q;
  logic [NREG-1:0] tag_d;
  logic            wr_en;

  assign wr_en = we & ~lock;

  always_comb begin
    tag_d = tag_q;
    if (32'(widx) < NREG) tag_d[widx] = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tag_q <= '0;
    else if (wr_en) tag_q <= tag_d;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rtag[g] = (32'(ridx[g]) < NREG) ? tag_q[ridx[g]] : 1'b0;
  end

  // R8: no tag changes while a loop holds the lock
  a_r8_tag_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(tag_q));
endmodule

// File: rtl/seq_len_csr.sv
`timescale 1ns/1ps
module seq_len_csr #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lock,
  input  logic             we,
  input  logic [LEN_W-1:0] wdata,
  output logic [LEN_W-1:0] len
);
  logic [LEN_W-1:0] len_q;
  logic             wr_en;

  assign wr_en = we & ~lock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     len_q <= LEN_W'(1);
    else if (wr_en) len_q <= wdata;
  end

  assign len = len_q;

  // R8: length frozen during a loop
  a_r8_len_locked: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(len_q));
endmodule

// File: rtl/seq_opnd_offset.sv
`timescale 1ns/1ps
module seq_opnd_offset #(
  parameter int NREG  = 32,
  parameter int LEN_W = 6,
  parameter bit APPLY = 1'b1,
  localparam int RW   = $clog2(NREG),
  localparam int SUM_W = ((LEN_W > RW) ? LEN_W : RW) + 1
) (
  input  logic [RW-1:0]    base,
  input  logic             active,
  input  logic [LEN_W-1:0] elem,
  output logic [RW-1:0]    idx,
  output logic             ovf
);
  if (APPLY) begin : g_offset
    logic [SUM_W-1:0] sum;
    assign sum = SUM_W'(base) + SUM_W'(elem);
    assign idx = active ? sum[RW-1:0] : base;
    assign ovf = active && (sum > SUM_W'(NREG - 1));
  end else begin : g_bypass
    logic unused_in;
    assign unused_in = active ^ (^elem);
    assign idx = base;
    assign ovf = 1'b0;
  end
endmodule

// File: rtl/seq_elem_ctrl.sv
`timescale 1ns/1ps
module seq_elem_ctrl
  import seq_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter bit TRAP  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             any_tag,
  input  logic [LEN_W-1:0] cnt_in,
  input  logic             out_ready,
  input  logic             ovf,
  output logic             in_ready,
  output logic             out_valid,
  output logic [LEN_W-1:0] elem,
  output logic             pc_advance,
  output logic             exc_valid,
  output logic [1:0]       exc_code,
  output logic             busy
);
  seq_state_e       state_q, state_d;
  logic [LEN_W-1:0] elem_q, elem_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [1:0]       code_q, code_d;
  logic             last;
  logic             elem_en, cnt_en, code_en;

  assign last = (elem_q == cnt_q - LEN_W'(1));

  always_comb begin
    state_d    = state_q;
    elem_d     = elem_q;
    cnt_d      = cnt_q;
    code_d     = code_q;
    in_ready   = 1'b0;
    out_valid  = 1'b0;
    pc_advance = 1'b0;
    exc_valid  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        in_ready = 1'b1;
        if (in_valid) begin
          if (TRAP && any_tag) begin
            state_d = ST_FAULT;
            code_d  = EXC_TAGGED;
          end else begin
            state_d = ST_ISSUE;
            elem_d  = '0;
            cnt_d   = cnt_in;
          end
        end
      end
      ST_ISSUE: begin
        if (ovf) begin
          state_d = ST_FAULT;
          code_d  = EXC_RANGE;
        end else begin
          out_valid = 1'b1;
          if (out_ready) begin
            if (last) begin
              pc_advance = 1'b1;
              state_d    = ST_IDLE;
            end else begin
              elem_d = elem_q + LEN_W'(1);
            end
          end
        end
      end
      ST_FAULT: begin
        exc_valid = 1'b1;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign elem_en = ((state_q == ST_IDLE) && in_valid) || (out_valid && out_ready);
  assign cnt_en  = (state_q == ST_IDLE) && in_valid;
  assign code_en = (state_d == ST_FAULT) && (state_q != ST_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       elem_q <= '0;
    else if (elem_en) elem_q <= elem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LEN_W'(1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= EXC_NONE;
    else if (code_en) code_q <= code_d;
  end

  assign elem     = elem_q;
  assign busy     = (state_q != ST_IDLE);
  assign exc_code = exc_valid ? code_q : EXC_NONE;

  // R3: nothing issues in the cycle after the final element
  a_r3_no_issue_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pc_advance |=> !out_valid);
  // R3: element index never reaches the captured count
  a_r3_elem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (elem_q < cnt_q));
  // R2: every issue run starts at element zero
  a_r2_first_elem_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (elem_q == '0));
  // R7: exception is a single-cycle pulse
  a_r7_exc_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> !exc_valid);
endmodule

// File: rtl/elem_issue_seq.sv
`timescale 1ns/1ps
module elem_issue_seq
  import seq_pkg::*;
#(
  parameter int NREG        = 32,
  parameter int LEN_W       = 6,
  parameter int OP_W        = 16,
  parameter bit TRAP_ON_TAG = 1'b0,
  localparam int RW         = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_len_we,
  input  logic [LEN_W-1:0] csr_len_wdata,
  input  logic             csr_tag_we,
  input  logic [RW-1:0]    csr_tag_idx,
  input  logic             csr_tag_val,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [RW-1:0]    in_rd,
  input  logic [RW-1:0]    in_rs1,
  input  logic [RW-1:0]    in_rs2,
  input  logic             in_rd_en,
  input  logic             in_rs1_en,
  input  logic             in_rs2_en,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OP_W-1:0]  out_op,
  output logic [RW-1:0]    out_rd,
  output logic [RW-1:0]    out_rs1,
  output logic [RW-1:0]    out_rs2,
  output logic             out_rd_en,
  output logic             out_rs1_en,
  output logic             out_rs2_en,
  output logic [LEN_W-1:0] out_elem,
  output logic             pc_advance,
  output logic             exc_valid,
  output logic [1:0]       exc_code
);
  logic [NOPND-1:0][RW-1:0] in_idx;
  logic [NOPND-1:0]         in_en;
  logic [NOPND-1:0]         tag_hit;
  logic [NOPND-1:0]         act_in;
  logic                     any_tag;
  logic [LEN_W-1:0]         len;
  logic [LEN_W-1:0]         cnt_in;
  logic                     busy;
  logic                     accept;

  logic [OP_W-1:0]          op_q;
  logic [NOPND-1:0][RW-1:0] idx_q;
  logic [NOPND-1:0]         en_q;
  logic [NOPND-1:0]         act_q;

  logic [NOPND-1:0][RW-1:0] idx_out;
  logic [NOPND-1:0]         ovf_v;
  logic                     ovf_any;

  assign in_idx = {in_rs2, in_rs1, in_rd};
  assign in_en  = {in_rs2_en, in_rs1_en, in_rd_en};

  seq_tag_table #(.NREG(NREG), .NRD(NOPND)) u_tags (
    .clk   (clk),
    .rst_n (rst_n),
    .lock  (busy),
    .we    (csr_tag_we),
    .widx  (csr_tag_idx),
    .wval  (csr_tag_val),
    .ridx  (in_idx),
    .rtag  (tag_hit)
  );

  seq_len_csr #(.LEN_W(LEN_W)) u_len (
    .clk   (clk),
    .rst_n (rst_n),
    .lock  (busy),
    .we    (csr_len_we),
    .wdata (csr_len_wdata),
    .len   (len)
  );

  assign act_in  = tag_hit & in_en;
  assign any_tag = |act_in;
  assign cnt_in  = !any_tag ? LEN_W'(1)
                 : ((len <= LEN_W'(1)) ? LEN_W'(1) : len);

  seq_elem_ctrl #(.LEN_W(LEN_W), .TRAP(TRAP_ON_TAG)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .any_tag    (any_tag),
    .cnt_in     (cnt_in),
    .out_ready  (out_ready),
    .ovf        (ovf_any),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .elem       (out_elem),
    .pc_advance (pc_advance),
    .exc_valid  (exc_valid),
    .exc_code   (exc_code),
    .busy       (busy)
  );

  assign accept = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      idx_q <= '0;
      en_q  <= '0;
      act_q <= '0;
    end else if (accept) begin
      op_q  <= in_op;
      idx_q <= in_idx;
      en_q  <= in_en;
      act_q <= act_in;
    end
  end

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    seq_opnd_offset #(.NREG(NREG), .LEN_W(LEN_W), .APPLY(!TRAP_ON_TAG)) u_off (
      .base   (idx_q[g]),
      .active (act_q[g]),
      .elem   (out_elem),
      .idx    (idx_out[g]),
      .ovf    (ovf_v[g])
    );
  end

  assign ovf_any    = |ovf_v;
  assign out_op     = op_q;
  assign out_rd     = idx_out[0];
  assign out_rs1    = idx_out[1];
  assign out_rs2    = idx_out[2];
  assign out_rd_en  = en_q[0];
  assign out_rs1_en = en_q[1];
  assign out_rs2_en = en_q[2];

  // R5: a stalled element keeps every output field
  a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_op) && $stable(out_rd) && $stable(out_rs1)
       && $stable(out_rs2) && $stable(out_elem)));
  // R3: decode is held off while elements are issued
  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R7: an exception cycle never carries an issue or a PC advance
  a_r7_exc_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!out_valid && !pc_advance));
endmodule

// File: tb/elem_issue_seq_bench.sv
`timescale 1ns/1ps
module elem_issue_seq_bench;
  localparam int NREG = 32;
  localparam int LEN_W = 6;
  localparam int OP_W = 16;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic             len_we_m, len_we_t, tag_we_m, tag_we_t;
  logic [LEN_W-1:0] len_wdata;
  logic [RW-1:0]    tag_idx;
  logic             tag_val;
  logic             in_valid_m, in_valid_t;
  logic [OP_W-1:0]  in_op;
  logic [RW-1:0]    in_rd, in_rs1, in_rs2;
  logic [2:0]       in_en;
  logic             out_ready;

  logic m_in_ready, m_out_valid, m_pc, m_exc;
  logic t_in_ready, t_out_valid, t_pc, t_exc;
  logic [OP_W-1:0] m_op, t_op;
  logic [RW-1:0] m_rd, m_rs1, m_rs2, t_rd, t_rs1, t_rs2;
  logic [2:0] m_en, t_en;
  logic [LEN_W-1:0] m_elem, t_elem;
  logic [1:0] m_code, t_code;

  elem_issue_seq #(.NREG(NREG), .LEN_W(LEN_W), .OP_W(OP_W), .TRAP_ON_TAG(1'b0)) u_elem_issue_seq (
    .clk(clk), .rst_n(rst_n),
    .csr_len_we(len_we_m), .csr_len_wdata(len_wdata),
    .csr_tag_we(tag_we_m), .csr_tag_idx(tag_idx), .csr_tag_val(tag_val),
    .in_valid(in_valid_m), .in_ready(m_in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_rd_en(in_en[0]), .in_rs1_en(in_en[1]), .in_rs2_en(in_en[2]),
    .out_valid(m_out_valid), .out_ready(out_ready), .out_op(m_op),
    .out_rd(m_rd), .out_rs1(m_rs1), .out_rs2(m_rs2),
    .out_rd_en(m_en[0]), .out_rs1_en(m_en[1]), .out_rs2_en(m_en[2]),
    .out_elem(m_elem), .pc_advance(m_pc), .exc_valid(m_exc), .exc_code(m_code)
  );

  elem_issue_seq #(.NREG(NREG), .LEN_W(LEN_W), .OP_W(OP_W), .TRAP_ON_TAG(1'b1)) u_trap (
    .clk(clk), .rst_n(rst_n),
    .csr_len_we(len_we_t), .csr_len_wdata(len_wdata),
    .csr_tag_we(tag_we_t), .csr_tag_idx(tag_idx), .csr_tag_val(tag_val),
    .in_valid(in_valid_t), .in_ready(t_in_ready), .in_op(in_op),
    .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
    .in_rd_en(in_en[0]), .in_rs1_en(in_en[1]), .in_rs2_en(in_en[2]),
    .out_valid(t_out_valid), .out_ready(out_ready), .out_op(t_op),
    .out_rd(t_rd), .out_rs1(t_rs1), .out_rs2(t_rs2),
    .out_rd_en(t_en[0]), .out_rs1_en(t_en[1]), .out_rs2_en(t_en[2]),
    .out_elem(t_elem), .pc_advance(t_pc), .exc_valid(t_exc), .exc_code(t_code)
  );

  logic sel;
  wire o_in_ready  = sel ? t_in_ready  : m_in_ready;
  wire o_out_valid = sel ? t_out_valid : m_out_valid;
  wire o_pc        = sel ? t_pc        : m_pc;
  wire o_exc       = sel ? t_exc       : m_exc;
  wire [1:0] o_code = sel ? t_code : m_code;
  wire [OP_W-1:0] o_op = sel ? t_op : m_op;
  wire [RW-1:0] o_rd  = sel ? t_rd  : m_rd;
  wire [RW-1:0] o_rs1 = sel ? t_rs1 : m_rs1;
  wire [RW-1:0] o_rs2 = sel ? t_rs2 : m_rs2;
  wire [2:0] o_en = sel ? t_en : m_en;
  wire [LEN_W-1:0] o_elem = sel ? t_elem : m_elem;

  int errors = 0;
  int checks = 0;
  bit mtag [NREG];
  int mlen;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_count(input bit any, input int len);
    if (!any) return 1;
    return (len <= 1) ? 1 : len;
  endfunction

  task automatic set_tag(input int idx, input bit val);
    tag_idx = RW'(idx); tag_val = val; tag_we_m = 1'b1; tag_we_t = 1'b1;
    @(negedge clk);
    tag_we_m = 1'b0; tag_we_t = 1'b0;
    mtag[idx] = val;
  endtask

  task automatic set_len(input int v);
    len_wdata = LEN_W'(v); len_we_m = 1'b1; len_we_t = 1'b1;
    @(negedge clk);
    len_we_m = 1'b0; len_we_t = 1'b0;
    mlen = v;
  endtask

  task automatic run_instr(input bit trap, input int op, input int rd, input int rs1,
                           input int rs2, input bit [2:0] en, input int rdy_pct,
                           input bit poke);
    int base [3];
    bit act [3];
    bit any;
    int cnt, ovf_e, e, guard;
    bit rdy;
    base[0] = rd; base[1] = rs1; base[2] = rs2;
    any = 1'b0;
    for (int i = 0; i < 3; i++) begin
      act[i] = en[i] && mtag[base[i]];
      any |= act[i];
    end
    cnt = exp_count(any, mlen);
    ovf_e = cnt;
    if (!trap) begin
      for (int k = cnt - 1; k >= 0; k--)
        for (int i = 0; i < 3; i++)
          if (act[i] && base[i] + k > NREG - 1) ovf_e = k;
    end
    sel = trap;
    in_op = OP_W'(op); in_rd = RW'(rd); in_rs1 = RW'(rs1); in_rs2 = RW'(rs2); in_en = en;
    if (trap) in_valid_t = 1'b1; else in_valid_m = 1'b1;
    #1;
    chk(o_in_ready == 1'b1, "R3 idle ready before accept", o_in_ready, 1);
    @(negedge clk);
    in_valid_m = 1'b0; in_valid_t = 1'b0;
    if (trap && any) begin
      out_ready = 1'b1;
      #1;
      chk(o_exc == 1'b1, "R9 trap exception", o_exc, 1);
      chk(o_code == 2'd1, "R9 trap code", o_code, 1);
      chk(o_out_valid == 1'b0, "R9 trap no issue", o_out_valid, 0);
      chk(o_pc == 1'b0, "R9 trap no pc advance", o_pc, 0);
      @(negedge clk);
    end else begin
      e = 0; guard = 0;
      while (e < cnt && guard < 4000) begin
        guard++;
        rdy = ($urandom % 100) < rdy_pct;
        out_ready = rdy;
        if (poke && guard == 1) begin
          len_wdata = LEN_W'(9); len_we_m = 1'b1;
          tag_idx = RW'(3); tag_val = ~mtag[3]; tag_we_m = 1'b1;
        end
        #1;
        if (e == ovf_e) begin
          chk(o_out_valid == 1'b0, "R7 range element not issued", o_out_valid, 0);
          chk(o_pc == 1'b0, "R7 no pc advance", o_pc, 0);
          @(negedge clk);
          #1;
          chk(o_exc == 1'b1, "R7 range exception", o_exc, 1);
          chk(o_code == 2'd2, "R7 range code", o_code, 2);
          chk(o_pc == 1'b0, "R7 no pc advance on fault", o_pc, 0);
          @(negedge clk);
          break;
        end
        chk(o_out_valid == 1'b1, "R3 element valid", o_out_valid, 1);
        chk(o_in_ready == 1'b0, "R3 decode held during loop", o_in_ready, 0);
        chk(o_op == OP_W'(op), "R2 op unchanged", o_op, op);
        chk(o_en == en, "R10 enables unchanged", o_en, en);
        chk(o_elem == LEN_W'(e), "R5 element index", o_elem, e);
        chk(o_rd == RW'(act[0] ? base[0] + e : base[0]), "R4 rd number", o_rd,
            act[0] ? base[0] + e : base[0]);
        chk(o_rs1 == RW'(act[1] ? base[1] + e : base[1]), "R4 rs1 number", o_rs1,
            act[1] ? base[1] + e : base[1]);
        chk(o_rs2 == RW'(act[2] ? base[2] + e : base[2]), "R4 rs2 number", o_rs2,
            act[2] ? base[2] + e : base[2]);
        chk(o_pc == (rdy && e == cnt - 1), "R3 pc advance only on final handshake",
            o_pc, rdy && e == cnt - 1);
        @(negedge clk);
        len_we_m = 1'b0; tag_we_m = 1'b0;
        if (rdy) e++;
      end
      if (ovf_e == cnt) begin
        #1;
        chk(o_out_valid == 1'b0, "R3 no extra issue", o_out_valid, 0);
      end
    end
    out_ready = 1'b0;
    #1;
    chk(o_in_ready == 1'b1, "R3 ready again after loop", o_in_ready, 1);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1d5e_a0c3);
    sel = 1'b0;
    rst_n = 1'b0;
    len_we_m = 0; len_we_t = 0; tag_we_m = 0; tag_we_t = 0;
    len_wdata = '0; tag_idx = '0; tag_val = 0;
    in_valid_m = 0; in_valid_t = 0; in_op = '0; in_rd = '0; in_rs1 = '0; in_rs2 = '0;
    in_en = '0; out_ready = 0;
    for (int i = 0; i < NREG; i++) mtag[i] = 1'b0;
    mlen = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(m_in_ready == 1'b1, "R1 reset in_ready", m_in_ready, 1);
    chk(m_out_valid == 1'b0, "R1 reset out_valid", m_out_valid, 0);
    chk(m_exc == 1'b0, "R1 reset exc_valid", m_exc, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(m_in_ready == 1'b1 && m_out_valid == 1'b0, "R1 idle after release", m_out_valid, 0);
    @(negedge clk);

    // R1: tags clear after reset -> single pass
    run_instr(0, 16'h1234, 5, 6, 7, 3'b111, 100, 0);
    // R1/R6: length 1 after reset -> tagged issues once
    set_tag(5, 1);
    run_instr(0, 16'h2222, 5, 6, 7, 3'b111, 100, 0);
    // R3/R4: four elements, then with stalls (R5)
    set_len(4);
    run_instr(0, 16'h3333, 5, 6, 7, 3'b111, 100, 0);
    run_instr(0, 16'h3334, 1, 5, 5, 3'b111, 40, 0);
    // R6: length zero
    set_len(0);
    run_instr(0, 16'h4444, 5, 5, 5, 3'b111, 100, 0);
    // R10: tagged register behind a disabled operand
    set_len(4);
    set_tag(9, 1);
    run_instr(0, 16'h5555, 1, 2, 9, 3'b011, 100, 0);
    run_instr(0, 16'h5556, 1, 2, 9, 3'b111, 100, 0);
    // R7: range overflow at element 2
    set_len(5);
    set_tag(30, 1);
    run_instr(0, 16'h6666, 4, 30, 8, 3'b111, 70, 0);
    // R8: writes during a loop are ignored
    set_tag(3, 0);
    set_len(4);
    set_tag(2, 1);
    run_instr(0, 16'h7777, 2, 0, 1, 3'b111, 100, 1);
    run_instr(0, 16'h7778, 0, 3, 1, 3'b111, 100, 0);
    run_instr(0, 16'h7779, 2, 0, 1, 3'b111, 100, 0);
    // R9: trap build
    run_instr(1, 16'h8888, 5, 6, 7, 3'b111, 100, 0);
    run_instr(1, 16'h8889, 0, 6, 7, 3'b111, 100, 0);
    run_instr(1, 16'h888a, 5, 6, 7, 3'b110, 100, 0);

    // constrained random mix
    for (int n = 0; n < 150; n++) begin
      if ($urandom % 4 == 0) set_tag($urandom % NREG, $urandom % 2);
      if ($urandom % 6 == 0) set_len($urandom % 11);
      run_instr(($urandom % 6) == 0, $urandom % 65536, $urandom % NREG,
                $urandom % NREG, $urandom % NREG, 3'($urandom % 8),
                30 + ($urandom % 71), 0);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule